// File: doc/BRIEF.md
# Hardware Buffer Pool Manager

This block holds many independent pools of buffer pointers in on-chip stacks. Any of several requesters can take a pointer out of a pool (acquire) or hand one back (release). The requesters are a set of hardware ports plus one software port. The block never looks inside a pointer. It stores opaque values and hands them back, and it treats every pointer in a pool the same way.

A round-robin arbiter picks one pending request per clock. The chosen operation is carried out against the selected pool, and a response comes back one cycle later. The response carries the requester index, the operation, a success bit and, for a successful acquire, the pointer.

Each pool also keeps a fill level with two thresholds, an entry level and an exit level. Together they drive a depletion flag that has hysteresis. The flag is sent out twice: once as a replenish request toward software and once as a pause toward producers for lossless flow control. A small write port sets the two thresholds of one pool at a time.

Top module: `bufpool_mgr`

## Requirements
- R1: There are NUM_POOLS (default 64) pools, chosen by a 6-bit pool field on each request. An operation on one pool never changes the contents, count or flag of any other pool.
- R2: `req_op` = 1 is a release, which pushes the pointer. `req_op` = 0 is an acquire, which pops the most recently pushed pointer of that pool and returns it unchanged with `rsp_ok` = 1.
- R3: An acquire from an empty pool completes in the normal response cycle with `rsp_ok` = 0 and `rsp_ptr` = 0. It does not stall.
- R4: A release to a pool that already holds DEPTH (default 8) pointers completes with `rsp_ok` = 0. The pointer is dropped and the pool contents do not change.
- R5: At most one request is granted per clock. The grant goes to the first valid requester after the one granted last, in circular index order. Index 4 is the software port and indices 0 to 3 are the hardware ports. A request stays valid until it is granted.
- R6: Every grant gives exactly one response in the next cycle. `rsp_id` is the granted index and `rsp_op` repeats the operation. There is no response in a cycle that follows a cycle without a grant.
- R7: A pool's depletion flag is set whenever its count is at or below its entry level. The flag shows the count that results from an operation in the cycle after the grant.
- R8: Once set, the flag clears only when the count goes above the exit level. While the count sits between the two levels, the flag keeps its previous value.
- R9: Both `replenish_req` and `pause_req` carry the per-pool depletion flags, with bit p belonging to pool p.
- R10: When `cfg_we` is high, the write loads the entry and exit levels of pool `cfg_pool`, and the new levels take effect from the next cycle. A write with `cfg_exit` < `cfg_entry` is ignored.
- R11: After reset every pool is empty, every depletion flag is set, no response is valid, and every pool has entry level DEF_ENTRY (2) and exit level DEF_EXIT (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_HW+1 | Per-requester request pending |
| req_op | input | NUM_HW+1 | Per-requester operation, 1 release, 0 acquire |
| req_pool | input | 6*(NUM_HW+1) | Per-requester pool index, requester i at bits [6i+5:6i] |
| req_ptr | input | PTR_W*(NUM_HW+1) | Per-requester pointer to release |
| req_grant | output | NUM_HW+1 | One-hot grant in the current cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | 3 | Index of the requester being answered |
| rsp_op | output | 1 | Operation being answered |
| rsp_ok | output | 1 | 1 on success, 0 on empty acquire or full release |
| rsp_ptr | output | PTR_W | Acquired pointer, zero when none |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_pool | input | 6 | Pool whose thresholds are written |
| cfg_entry | input | 4 | New entry level |
| cfg_exit | input | 4 | New exit level |
| replenish_req | output | NUM_POOLS | Per-pool depletion flag toward software |
| pause_req | output | NUM_POOLS | Per-pool depletion flag toward producers |

## Verification
A bad stack pointer or count for a pool shows up at the next acquire from that pool. That acquire returns the wrong pointer, or gets a wrong success bit, one cycle after its grant. The flag vectors expose the same fault even sooner, in the very cycle after the faulty update, once the count crosses a threshold. A wrong arbiter rotation pointer shows as a grant to the wrong requester in the same cycle the requests are presented. Bad thresholds show as a flag edge one count too early or too late. The bench therefore compares the grant, every response field and both flag vectors against a behavioural model on every clock.

// File: rtl/bpm_pkg.sv
`timescale 1ns/1ps
package bpm_pkg;
   typedef enum logic {
      OP_ACQ = 1'b0,
      OP_REL = 1'b1
   } pool_op_e;
endpackage

// File: rtl/bpm_rr_arb.sv
`timescale 1ns/1ps
module bpm_rr_arb #(
   parameter int N = 5,
   localparam int IW = (N > 1) ? $clog2(N) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx,
   output logic          gnt_any
);
   if (N < 1) begin : g_bad_n
      $error("bpm_rr_arb: N must be at least 1");
   end

   logic [IW-1:0] last_q;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      gnt_any = 1'b0;
      for (int i = 0; i < N; i++) begin
         int k;
         k = int'(last_q) + 1 + i;
         if (k >= N) k = k - N;
         if (!gnt_any && req[IW'(k)]) begin
            gnt[IW'(k)] = 1'b1;
            gnt_idx     = IW'(k);
            gnt_any     = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last_q <= IW'(N - 1);
      else if (gnt_any) last_q <= gnt_idx;
   end

   // R5
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R5
   grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
endmodule

// File: rtl/bpm_pool_store.sv
`timescale 1ns/1ps
module bpm_pool_store
   import bpm_pkg::*;
#(
   parameter int NUM_POOLS = 64,
   parameter int DEPTH     = 8,
   parameter int PTR_W     = 32,
   parameter int ID_W      = 3,
   localparam int POOL_W   = $clog2(NUM_POOLS),
   localparam int CNT_W    = $clog2(DEPTH + 1),
   localparam int SLOT_W   = $clog2(DEPTH)
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             op_valid,
   input  pool_op_e                         op_kind,
   input  logic [POOL_W-1:0]                op_pool,
   input  logic [PTR_W-1:0]                 op_ptr,
   input  logic [ID_W-1:0]                  op_id,
   output logic                             rsp_valid,
   output logic [ID_W-1:0]                  rsp_id,
   output pool_op_e                         rsp_kind,
   output logic                             rsp_ok,
   output logic [PTR_W-1:0]                 rsp_ptr,
   output logic [NUM_POOLS-1:0][CNT_W-1:0]  cnt
);
   if (DEPTH < 2 || (1 << SLOT_W) != DEPTH) begin : g_bad_depth
      $error("bpm_pool_store: DEPTH must be a power of two, at least 2");
   end

   logic [PTR_W-1:0] mem [NUM_POOLS*DEPTH];
   logic [CNT_W-1:0] cur;
   logic             empty, full, do_pop, do_push;
   logic [SLOT_W-1:0] pop_slot, push_slot;

   assign cur       = cnt[op_pool];
   assign empty     = (cur == '0);
   assign full      = (cur == CNT_W'(DEPTH));
   assign pop_slot  = SLOT_W'(cur - 1'b1);
   assign push_slot = cur[SLOT_W-1:0];
   assign do_pop    = op_valid && (op_kind == OP_ACQ) && !empty;
   assign do_push   = op_valid && (op_kind == OP_REL) && !full;

   always_ff @(posedge clk) begin
      if (do_push) mem[{op_pool, push_slot}] <= op_ptr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (do_pop) begin
         cnt[op_pool] <= cur - 1'b1;
      end else if (do_push) begin
         cnt[op_pool] <= cur + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
         rsp_kind  <= OP_ACQ;
         rsp_ok    <= 1'b0;
         rsp_ptr   <= '0;
      end else begin
         rsp_valid <= op_valid;
         rsp_id    <= op_id;
         rsp_kind  <= op_kind;
         rsp_ok    <= do_pop || do_push;
         rsp_ptr   <= do_pop ? mem[{op_pool, pop_slot}] : '0;
      end
   end

   // R3
   empty_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_kind == OP_ACQ && cur == '0 |=> rsp_valid && !rsp_ok && rsp_ptr == '0);
   // R4
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_kind == OP_REL && full |=> rsp_valid && !rsp_ok);
   // R4
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur <= CNT_W'(DEPTH));
endmodule

// File: rtl/bpm_depl_track.sv
`timescale 1ns/1ps
module bpm_depl_track #(
   parameter int NUM_POOLS = 64,
   parameter int CNT_W     = 4,
   parameter int DEF_ENTRY = 2,
   parameter int DEF_EXIT  = 4,
   localparam int POOL_W   = $clog2(NUM_POOLS)
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_POOLS-1:0][CNT_W-1:0]  cnt,
   input  logic                             cfg_we,
   input  logic [POOL_W-1:0]                cfg_pool,
   input  logic [CNT_W-1:0]                 cfg_entry,
   input  logic [CNT_W-1:0]                 cfg_exit,
   output logic [NUM_POOLS-1:0]             low
);
   logic cfg_ok;
   assign cfg_ok = cfg_we && (cfg_exit >= cfg_entry);

   for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
      logic [CNT_W-1:0] ent_q, ext_q;
      logic             flag_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= CNT_W'(DEF_ENTRY);
            ext_q <= CNT_W'(DEF_EXIT);
         end else if (cfg_ok && cfg_pool == POOL_W'(p)) begin
            ent_q <= cfg_entry;
            ext_q <= cfg_exit;
         end
      end

      assign low[p] = (cnt[p] <= ent_q) ? 1'b1 :
                      (cnt[p] >  ext_q) ? 1'b0 : flag_q;

      always_ff @(posedge clk) begin
         if (!rst_n) flag_q <= 1'b1;
         else        flag_q <= low[p];
      end

      // R8
      exit_hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(low[p]) |-> cnt[p] > ext_q);
      // R7
      entry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(low[p]) |-> cnt[p] <= ent_q);
   end
endmodule

// File: rtl/bufpool_mgr.sv
`timescale 1ns/1ps
module bufpool_mgr
   import bpm_pkg::*;
#(
   parameter int NUM_POOLS = 64,
   parameter int DEPTH     = 8,
   parameter int PTR_W     = 32,
   parameter int NUM_HW    = 4,
   parameter int DEF_ENTRY = 2,
   parameter int DEF_EXIT  = 4,
   localparam int NREQ     = NUM_HW + 1,
   localparam int POOL_W   = $clog2(NUM_POOLS),
   localparam int CNT_W    = $clog2(DEPTH + 1),
   localparam int ID_W     = (NREQ > 1) ? $clog2(NREQ) : 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NREQ-1:0]         req_valid,
   input  logic [NREQ-1:0]         req_op,
   input  logic [NREQ*POOL_W-1:0]  req_pool,
   input  logic [NREQ*PTR_W-1:0]   req_ptr,
   output logic [NREQ-1:0]         req_grant,
   output logic                    rsp_valid,
   output logic [ID_W-1:0]         rsp_id,
   output logic                    rsp_op,
   output logic                    rsp_ok,
   output logic [PTR_W-1:0]        rsp_ptr,
   input  logic                    cfg_we,
   input  logic [POOL_W-1:0]       cfg_pool,
   input  logic [CNT_W-1:0]        cfg_entry,
   input  logic [CNT_W-1:0]        cfg_exit,
   output logic [NUM_POOLS-1:0]    replenish_req,
   output logic [NUM_POOLS-1:0]    pause_req
);
   if (DEF_EXIT < DEF_ENTRY || DEF_EXIT > DEPTH) begin : g_bad_thr
      $error("bufpool_mgr: need DEF_ENTRY <= DEF_EXIT <= DEPTH");
   end
   if (NUM_POOLS < 2 || NUM_HW < 1) begin : g_bad_size
      $error("bufpool_mgr: need at least two pools and one hardware port");
   end

   logic [ID_W-1:0]                 gnt_idx;
   logic                            gnt_any;
   pool_op_e                        sel_op;
   logic [POOL_W-1:0]               sel_pool;
   logic [PTR_W-1:0]                sel_ptr;
   pool_op_e                        rsp_kind;
   logic [NUM_POOLS-1:0][CNT_W-1:0] pool_cnt;
   logic [NUM_POOLS-1:0]            low;

   bpm_rr_arb #(.N(NREQ)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_valid),
      .gnt     (req_grant),
      .gnt_idx (gnt_idx),
      .gnt_any (gnt_any)
   );

   always_comb begin
      sel_op   = OP_ACQ;
      sel_pool = '0;
      sel_ptr  = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (req_grant[i]) begin
            sel_op   = pool_op_e'(req_op[i]);
            sel_pool = req_pool[i*POOL_W +: POOL_W];
            sel_ptr  = req_ptr[i*PTR_W +: PTR_W];
         end
      end
   end

   bpm_pool_store #(
      .NUM_POOLS (NUM_POOLS),
      .DEPTH     (DEPTH),
      .PTR_W     (PTR_W),
      .ID_W      (ID_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (gnt_any),
      .op_kind   (sel_op),
      .op_pool   (sel_pool),
      .op_ptr    (sel_ptr),
      .op_id     (gnt_idx),
      .rsp_valid (rsp_valid),
      .rsp_id    (rsp_id),
      .rsp_kind  (rsp_kind),
      .rsp_ok    (rsp_ok),
      .rsp_ptr   (rsp_ptr),
      .cnt       (pool_cnt)
   );

   assign rsp_op = (rsp_kind == OP_REL);

   bpm_depl_track #(
      .NUM_POOLS (NUM_POOLS),
      .CNT_W     (CNT_W),
      .DEF_ENTRY (DEF_ENTRY),
      .DEF_EXIT  (DEF_EXIT)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (pool_cnt),
      .cfg_we    (cfg_we),
      .cfg_pool  (cfg_pool),
      .cfg_entry (cfg_entry),
      .cfg_exit  (cfg_exit),
      .low       (low)
   );

   assign replenish_req = low;
   assign pause_req     = low;

   // R6
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_any |=> rsp_valid && rsp_id == $past(gnt_idx));
   // R6
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_any |=> !rsp_valid);
endmodule

// File: tb/test_bufpool_mgr.sv
`timescale 1ns/1ps
module test_bufpool_mgr;
   localparam int NP = 64, DEPTH = 8, PW = 32, NREQ = 5, PLW = 6, CW = 4;
   localparam int DEF_EN = 2, DEF_EX = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic               rst_n;
   logic [NREQ-1:0]    req_valid, req_op, req_grant;
   logic [NREQ*PLW-1:0] req_pool;
   logic [NREQ*PW-1:0] req_ptr;
   logic               rsp_valid, rsp_op, rsp_ok;
   logic [2:0]         rsp_id;
   logic [PW-1:0]      rsp_ptr;
   logic               cfg_we;
   logic [PLW-1:0]     cfg_pool;
   logic [CW-1:0]      cfg_entry, cfg_exit;
   logic [NP-1:0]      replenish_req, pause_req;

   bufpool_mgr i_bufpool_mgr (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_pool(req_pool), .req_ptr(req_ptr), .req_grant(req_grant),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_op(rsp_op), .rsp_ok(rsp_ok),
      .rsp_ptr(rsp_ptr), .cfg_we(cfg_we), .cfg_pool(cfg_pool),
      .cfg_entry(cfg_entry), .cfg_exit(cfg_exit),
      .replenish_req(replenish_req), .pause_req(pause_req)
   );

   logic [PW-1:0] mq [NP][$];
   int            m_ent [NP];
   int            m_ext [NP];
   bit            m_flag [NP];
   int            m_last;
   bit            e_valid, e_op, e_ok;
   int            e_id, e_gnt;
   logic [PW-1:0] e_ptr;
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;
   string         scn = "reset";
   logic [31:0]   lfsr = 32'h1ACE_5EED;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] %s: actual %h expected %h", tag, scn, what, act, exp);
      end
   endtask

   function automatic logic [NP-1:0] flag_vec();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = m_flag[p];
      return v;
   endfunction

   function automatic logic [31:0] next_rand();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr;
   endfunction

   task automatic post(input int id, input bit op, input int pool, input logic [PW-1:0] ptr);
      req_valid[id] = 1'b1;
      req_op[id]    = op;
      req_pool[id*PLW +: PLW] = PLW'(pool);
      req_ptr[id*PW +: PW]    = ptr;
   endtask

   // One clock: model the edge, then compare at the following falling edge.
   task automatic tick();
      logic [NREQ-1:0] eg;
      int pool;
      #1;
      e_gnt = -1;
      for (int i = 0; i < NREQ; i++) begin
         int k = (m_last + 1 + i) % NREQ;
         if (e_gnt < 0 && req_valid[k]) e_gnt = k;
      end
      eg = (e_gnt >= 0) ? NREQ'(1 << e_gnt) : '0;
      // R5 round-robin grant
      chk(req_grant == eg, "R5", "grant", 64'(req_grant), 64'(eg));
      e_valid = (e_gnt >= 0);
      if (e_valid) begin
         m_last = e_gnt;
         e_id   = e_gnt;
         e_op   = req_op[e_gnt];
         pool   = int'(req_pool[e_gnt*PLW +: PLW]);
         e_ptr  = '0;
         if (e_op) begin
            e_ok = (mq[pool].size() < DEPTH);
            if (e_ok) mq[pool].push_back(req_ptr[e_gnt*PW +: PW]);
         end else begin
            e_ok = (mq[pool].size() > 0);
            if (e_ok) e_ptr = mq[pool].pop_back();
         end
      end
      // R10 threshold write, ignored when exit < entry
      if (cfg_we && cfg_exit >= cfg_entry) begin
         m_ent[int'(cfg_pool)] = int'(cfg_entry);
         m_ext[int'(cfg_pool)] = int'(cfg_exit);
      end
      for (int p = 0; p < NP; p++) begin
         int c = mq[p].size();
         if (c <= m_ent[p])     m_flag[p] = 1'b1;
         else if (c > m_ext[p]) m_flag[p] = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid == e_valid, "R6", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
      if (e_valid) begin
         chk(rsp_id == 3'(e_id), "R6", "rsp_id", 64'(rsp_id), 64'(e_id));
         chk(rsp_op == e_op, "R6", "rsp_op", 64'(rsp_op), 64'(e_op));
         chk(rsp_ok == e_ok, e_op ? "R4" : "R3", "rsp_ok", 64'(rsp_ok), 64'(e_ok));
         chk(rsp_ptr == e_ptr, "R2", "rsp_ptr", 64'(rsp_ptr), 64'(e_ptr));
      end
      chk(replenish_req == flag_vec(), "R7 R8", "replenish", replenish_req, flag_vec());
      chk(pause_req == flag_vec(), "R9", "pause", pause_req, flag_vec());
      if (e_gnt >= 0) req_valid[e_gnt] = 1'b0;
      cfg_we = 1'b0;
   endtask

   task automatic do_op(input int id, input bit op, input int pool, input logic [PW-1:0] ptr);
      post(id, op, pool, ptr);
      while (req_valid[id]) tick();
   endtask

   task automatic do_cfg(input int pool, input int en, input int ex);
      cfg_we = 1'b1; cfg_pool = PLW'(pool); cfg_entry = CW'(en); cfg_exit = CW'(ex);
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = '0; req_op = '0; req_pool = '0; req_ptr = '0;
      cfg_we = 1'b0; cfg_pool = '0; cfg_entry = '0; cfg_exit = '0;
      for (int p = 0; p < NP; p++) begin
         m_ent[p] = DEF_EN; m_ext[p] = DEF_EX; m_flag[p] = 1'b1;
      end
      m_last = NREQ - 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      chk(rsp_valid == 1'b0, "R11", "rsp_valid", 64'(rsp_valid), 64'd0);
      chk(replenish_req == '1, "R11", "flags", replenish_req, {NP{1'b1}});
      chk(req_grant == '0, "R11", "grant", 64'(req_grant), 64'd0);
      tick();

      scn = "R2 lifo order";
      do_op(4, 1'b1, 5, 32'hA000_0001);
      do_op(4, 1'b1, 5, 32'hB000_0002);
      do_op(4, 1'b1, 5, 32'hC000_0003);
      do_op(4, 1'b0, 5, '0);
      do_op(4, 1'b0, 5, '0);
      do_op(4, 1'b0, 5, '0);

      scn = "R1 pool independence";
      do_op(0, 1'b1, 5, 32'h5555_0005);
      do_op(1, 1'b1, 6, 32'h6666_0006);
      do_op(2, 1'b0, 6, '0);
      do_op(3, 1'b0, 5, '0);

      scn = "R7 R8 hysteresis and R11 defaults";
      for (int i = 0; i < DEPTH; i++) do_op(4, 1'b1, 5, 32'hD000_0000 + i);
      for (int i = 0; i < 6; i++) do_op(1, 1'b0, 5, '0);

      scn = "R4 full pool";
      for (int i = 0; i < DEPTH; i++) do_op(2, 1'b1, 9, 32'hE000_0000 + i);
      do_op(2, 1'b1, 9, 32'hDEAD_BEEF);
      do_op(2, 1'b0, 9, '0);

      scn = "R3 empty pool";
      do_op(3, 1'b0, 63, '0);
      do_op(4, 1'b0, 63, '0);

      scn = "R5 R6 arbitration";
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < NREQ; i++) post(i, i[0], 10 + i, 32'hF000_0000 + i);
         repeat (NREQ) tick();
      end
      post(1, 1'b1, 20, 32'h1); post(3, 1'b1, 21, 32'h3);
      tick(); tick(); tick();

      scn = "R10 thresholds";
      do_cfg(5, 6, 7);
      while (mq[5].size() < DEPTH) do_op(0, 1'b1, 5, 32'h7700_0000);
      do_cfg(5, 5, 3);
      do_op(0, 1'b0, 5, '0);
      do_op(0, 1'b0, 5, '0);
      do_op(0, 1'b0, 5, '0);

      scn = "mixed traffic";
      for (int c = 0; c < 400; c++) begin
         for (int i = 0; i < NREQ; i++) begin
            logic [31:0] r = next_rand();
            if (!req_valid[i] && r[2:0] < 3'd5)
               post(i, r[3], int'(r[5:4]), next_rand());
         end
         if (next_rand() % 16 == 0) begin
            logic [31:0] r = next_rand();
            cfg_we = 1'b1; cfg_pool = PLW'(r[1:0]);
            cfg_entry = CW'(r[7:4] % 9); cfg_exit = CW'(r[11:8] % 9);
         end
         tick();
      end
      req_valid = '0;
      tick(); tick();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule